// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the register file that software uses to program and watch one DMA channel. It sits on a simple 32-bit register bus that accepts 16-bit or 32-bit accesses. It holds the channel's descriptor pointers, start address, configuration word, the count and stride values for both dimensions, shadows of the engine's current state, a status word and a peripheral routing word. A separate transfer engine reads the programmed values from the output ports. It receives one-cycle start and stop commands, and it returns the current pointer, address and counts, together with done and error events.

Writing the configuration word starts or stops the channel directly. While the channel runs, software can still rewrite the configuration word and clear status bits. Writes to every other register are discarded, so a transfer in flight cannot be corrupted. A write to an unused slot is dropped and raises a one-cycle flag.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every slot reads as zero, except the routing word at byte offset 0x2C, which reads as the parameter PMAP_RST.
- R2: Slot k sits at byte offset 4*k, with address bits 1:0 ignored. A 32-bit read (bus_wide_i=1) returns the whole register, zero-extended. A 16-bit read returns only bits 15:0, with the upper half zero. Unused slots 0x0C, 0x34 and 0x3C read as zero.
- R3: The 32-bit registers are the next pointer (0x00), start address (0x04), current pointer (0x20) and current address (0x24). They take all 32 bits on a 32-bit write and only bits 15:0 on a 16-bit write, with bits 31:16 kept. The 16-bit registers (config 0x08, X count 0x10, X stride 0x14, Y count 0x18, Y stride 0x1C, routing 0x2C, current X count 0x30, current Y count 0x38) store bits 15:0 of any write.
- R4: While the run bit is set, writes to the pointers, addresses, counts, strides, current counts and routing word are discarded.
- R5: A write to config stores the value. If bit 0 of the value is 1, the run bit is set and start_o pulses for one cycle after the write. If bit 0 is 0, the run bit is cleared and stop_o pulses for one cycle.
- R6: Status (0x28) reads as {12'b0, run, 1'b0, err, done}. Writing a 1 to bit 0 clears done and writing a 1 to bit 1 clears err. Writing 0 leaves them unchanged, and the run bit cannot be written through status.
- R7: eng_done_i sets done and clears run, unless a config write happens in the same cycle. eng_err_i sets err. An engine event that sets a bit wins over a software clear in the same cycle.
- R8: A permitted write to the routing word keeps the current bit 6 (the channel-type bit) and takes every other bit from the write data.
- R9: A write to an unused slot changes no register and raises bad_wr_o for exactly the following cycle.
- R10: eng_upd_i loads the current pointer, current address and both current counts from the engine inputs, whether or not the channel runs, and takes priority over a bus write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_wide_i | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_addr_i | input | AW | Byte offset within the channel |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| eng_upd_i | input | 1 | Engine current-state update strobe |
| eng_desc_i | input | 32 | Engine current descriptor pointer |
| eng_addr_i | input | 32 | Engine current address |
| eng_xcnt_i | input | 16 | Engine current X count |
| eng_ycnt_i | input | 16 | Engine current Y count |
| eng_done_i | input | 1 | Engine finished the work |
| eng_err_i | input | 1 | Engine saw an error |
| run_o | output | 1 | Channel run bit |
| start_o | output | 1 | One-cycle start command |
| stop_o | output | 1 | One-cycle stop command |
| bad_wr_o | output | 1 | One-cycle flag for a write to an unused slot |
| cfg_o | output | 16 | Configuration word |
| next_desc_o | output | 32 | Next descriptor pointer |
| start_addr_o | output | 32 | Start address |
| xcnt_o | output | 16 | X count |
| xmod_o | output | 16 | X stride |
| ycnt_o | output | 16 | Y count |
| ymod_o | output | 16 | Y stride |
| pmap_o | output | 16 | Peripheral routing word |

## Verification
The bench tries full-width and half-width writes to the 32-bit registers, which separates a correct merge of the low half from one that clears or replaces the upper half. It repeats the same register writes with the channel idle and with it running, so a guard that is missing or that uses the wrong condition is exposed. Status is driven with zero, single-bit and all-bit write patterns, and with an engine event that arrives in the same cycle as a clear, which shows both the write-one-to-clear behaviour and which side has priority. Writes to unused slots, and the routing write with its preserved bit, are checked both through readback and through the per-cycle outputs.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

  localparam int DATA_W = 32;
  localparam int HALF_W = 16;

  // slot indices (byte offset / 4)
  localparam int S_NDP  = 0;
  localparam int S_SA   = 1;
  localparam int S_CFG  = 2;
  localparam int S_XC   = 4;
  localparam int S_XM   = 5;
  localparam int S_YC   = 6;
  localparam int S_YM   = 7;
  localparam int S_CDP  = 8;
  localparam int S_CA   = 9;
  localparam int S_ST   = 10;
  localparam int S_PM   = 11;
  localparam int S_CXC  = 12;
  localparam int S_CYC  = 14;
  localparam int S_BASE = 16;

  localparam int ST_DONE_B = 0;
  localparam int ST_ERR_B  = 1;
  localparam int CFG_EN_B  = 0;
  localparam int PM_TYPE_B = 6;

  function automatic logic slot_unused(input int k);
    return (k >= S_BASE) || (k == 3) || (k == 13) || (k == 15);
  endfunction

  // full write or low-half merge
  function automatic logic [DATA_W-1:0] merge_word(input logic [DATA_W-1:0] old,
                                                   input logic [DATA_W-1:0] wd,
                                                   input logic wide);
    return wide ? wd : {old[DATA_W-1:HALF_W], wd[HALF_W-1:0]};
  endfunction

  function automatic logic [HALF_W-1:0] pmap_merge(input logic [HALF_W-1:0] old,
                                                   input logic [HALF_W-1:0] wd);
    logic [HALF_W-1:0] keep;
    keep = '0;
    keep[PM_TYPE_B] = 1'b1;
    return (old & keep) | (wd & ~keep);
  endfunction

  function automatic logic clear_then_set(input logic old, input logic clr, input logic set);
    return (old & ~clr) | set;
  endfunction

endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
  import dma_regs_pkg::*;
#(
  parameter int IDX_W = 4,
  localparam int SLOTS = 1 << IDX_W
)(
  input  logic [IDX_W-1:0] idx_i,
  output logic [SLOTS-1:0] sel_o,
  output logic             unused_o
);
  logic [SLOTS-1:0] free_hit;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign sel_o[k]    = (idx_i == IDX_W'(k));
    assign free_hit[k] = sel_o[k] & slot_unused(k);
  end

  assign unused_o = |free_hit;
endmodule

// File: rtl/dma_reg_status.sv
module dma_reg_status
  import dma_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic              cfg_en_i,
  input  logic              st_wr_i,
  input  logic [HALF_W-1:0] st_wdata_i,
  input  logic              eng_done_i,
  input  logic              eng_err_i,
  output logic              run_o,
  output logic              done_o,
  output logic              err_o,
  output logic              start_o,
  output logic              stop_o
);
  logic run_q, done_q, err_q, start_q, stop_q;
  logic clr_done, clr_err;

  assign clr_done = st_wr_i & st_wdata_i[ST_DONE_B];
  assign clr_err  = st_wr_i & st_wdata_i[ST_ERR_B];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      if (cfg_wr_i)        run_q <= cfg_en_i;
      else if (eng_done_i) run_q <= 1'b0;
      done_q  <= clear_then_set(done_q, clr_done, eng_done_i);
      err_q   <= clear_then_set(err_q, clr_err, eng_err_i);
      start_q <= cfg_wr_i & cfg_en_i;
      stop_q  <= cfg_wr_i & ~cfg_en_i;
    end
  end

  assign run_o   = run_q;
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign start_o = start_q;
  assign stop_o  = stop_q;
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int          AW       = 6,
  parameter logic [15:0] PMAP_RST = 16'h0045
)(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic              bus_wide_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              eng_upd_i,
  input  logic [DATA_W-1:0] eng_desc_i,
  input  logic [DATA_W-1:0] eng_addr_i,
  input  logic [HALF_W-1:0] eng_xcnt_i,
  input  logic [HALF_W-1:0] eng_ycnt_i,
  input  logic              eng_done_i,
  input  logic              eng_err_i,
  output logic              run_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              bad_wr_o,
  output logic [HALF_W-1:0] cfg_o,
  output logic [DATA_W-1:0] next_desc_o,
  output logic [DATA_W-1:0] start_addr_o,
  output logic [HALF_W-1:0] xcnt_o,
  output logic [HALF_W-1:0] xmod_o,
  output logic [HALF_W-1:0] ycnt_o,
  output logic [HALF_W-1:0] ymod_o,
  output logic [HALF_W-1:0] pmap_o
);
  localparam int IDX_W = AW - 2;
  localparam int SLOTS = 1 << IDX_W;

  logic [SLOTS-1:0] sel;
  logic             hit_unused;
  logic             unused_lo;
  assign unused_lo = ^bus_addr_i[1:0];

  dma_reg_decode #(.IDX_W(IDX_W)) u_dec (
    .idx_i   (bus_addr_i[AW-1:2]),
    .sel_o   (sel),
    .unused_o(hit_unused)
  );

  // named events for the checker
  logic run, done, err;
  logic cfg_wr, st_wr, gw;
  assign cfg_wr = bus_wr_i & sel[S_CFG];
  assign st_wr  = bus_wr_i & sel[S_ST];
  assign gw     = bus_wr_i & ~run;

  dma_reg_status u_st (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_wr_i  (cfg_wr),
    .cfg_en_i  (bus_wdata_i[CFG_EN_B]),
    .st_wr_i   (st_wr),
    .st_wdata_i(bus_wdata_i[HALF_W-1:0]),
    .eng_done_i(eng_done_i),
    .eng_err_i (eng_err_i),
    .run_o     (run),
    .done_o    (done),
    .err_o     (err),
    .start_o   (start_o),
    .stop_o    (stop_o)
  );

  logic [DATA_W-1:0] ndp_q, sa_q, cdp_q, ca_q;
  logic [HALF_W-1:0] cfg_q, xc_q, xm_q, yc_q, ym_q, pm_q, cxc_q, cyc_q;
  logic              bad_q;
  logic [HALF_W-1:0] wd16;
  assign wd16 = bus_wdata_i[HALF_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ndp_q <= '0; sa_q <= '0; cdp_q <= '0; ca_q <= '0;
      cfg_q <= '0; xc_q <= '0; xm_q <= '0; yc_q <= '0; ym_q <= '0;
      pm_q  <= PMAP_RST;
      cxc_q <= '0; cyc_q <= '0;
      bad_q <= 1'b0;
    end else begin
      if (gw & sel[S_NDP]) ndp_q <= merge_word(ndp_q, bus_wdata_i, bus_wide_i);
      if (gw & sel[S_SA])  sa_q  <= merge_word(sa_q, bus_wdata_i, bus_wide_i);
      if (cfg_wr)          cfg_q <= wd16;
      if (gw & sel[S_XC])  xc_q  <= wd16;
      if (gw & sel[S_XM])  xm_q  <= wd16;
      if (gw & sel[S_YC])  yc_q  <= wd16;
      if (gw & sel[S_YM])  ym_q  <= wd16;
      if (gw & sel[S_PM])  pm_q  <= pmap_merge(pm_q, wd16);
      if (eng_upd_i) begin
        cdp_q <= eng_desc_i;
        ca_q  <= eng_addr_i;
        cxc_q <= eng_xcnt_i;
        cyc_q <= eng_ycnt_i;
      end else begin
        if (gw & sel[S_CDP]) cdp_q <= merge_word(cdp_q, bus_wdata_i, bus_wide_i);
        if (gw & sel[S_CA])  ca_q  <= merge_word(ca_q, bus_wdata_i, bus_wide_i);
        if (gw & sel[S_CXC]) cxc_q <= wd16;
        if (gw & sel[S_CYC]) cyc_q <= wd16;
      end
      bad_q <= bus_wr_i & hit_unused;
    end
  end

  logic [HALF_W-1:0] st_word;
  assign st_word = {12'h000, run, 1'b0, err, done};

  logic [DATA_W-1:0] rd_full;
  always_comb begin
    rd_full = ({DATA_W{sel[S_NDP]}} & ndp_q)
            | ({DATA_W{sel[S_SA]}}  & sa_q)
            | ({DATA_W{sel[S_CDP]}} & cdp_q)
            | ({DATA_W{sel[S_CA]}}  & ca_q)
            | ({DATA_W{sel[S_CFG]}} & {16'h0, cfg_q})
            | ({DATA_W{sel[S_XC]}}  & {16'h0, xc_q})
            | ({DATA_W{sel[S_XM]}}  & {16'h0, xm_q})
            | ({DATA_W{sel[S_YC]}}  & {16'h0, yc_q})
            | ({DATA_W{sel[S_YM]}}  & {16'h0, ym_q})
            | ({DATA_W{sel[S_ST]}}  & {16'h0, st_word})
            | ({DATA_W{sel[S_PM]}}  & {16'h0, pm_q})
            | ({DATA_W{sel[S_CXC]}} & {16'h0, cxc_q})
            | ({DATA_W{sel[S_CYC]}} & {16'h0, cyc_q});
  end

  assign bus_rdata_o  = bus_wide_i ? rd_full : {16'h0, rd_full[HALF_W-1:0]};
  assign run_o        = run;
  assign bad_wr_o     = bad_q;
  assign cfg_o        = cfg_q;
  assign next_desc_o  = ndp_q;
  assign start_addr_o = sa_q;
  assign xcnt_o       = xc_q;
  assign xmod_o       = xm_q;
  assign ycnt_o       = yc_q;
  assign ymod_o       = ym_q;
  assign pmap_o       = pm_q;
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int AW = 6
)(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_wr_i,
  input logic [AW-1:0] bus_addr_i,
  input logic          eng_done_i,
  input logic          run_o,
  input logic          start_o,
  input logic          stop_o,
  input logic          bad_wr_o,
  input logic [31:0]   start_addr_o,
  input logic [15:0]   xcnt_o,
  input logic [15:0]   pmap_o
);
  logic cfg_hit;
  logic unused_lo;
  assign cfg_hit   = bus_wr_i && (bus_addr_i[AW-1:2] == (AW-2)'(2));
  assign unused_lo = ^bus_addr_i[1:0];

  // R5
  start_sets_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> run_o);
  // R5
  stop_clears_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> !run_o);
  // R5
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, stop_o}));
  // R4
  guard_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |=> $stable(start_addr_o));
  // R4
  guard_xcnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |=> $stable(xcnt_o));
  // R4
  guard_pmap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |=> $stable(pmap_o));
  // R7
  done_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done_i && !cfg_hit) |=> !run_o);
  // R9
  bad_wr_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_wr_o |-> $past(bus_wr_i));
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .eng_done_i  (eng_done_i),
  .run_o       (run_o),
  .start_o     (start_o),
  .stop_o      (stop_o),
  .bad_wr_o    (bad_wr_o),
  .start_addr_o(start_addr_o),
  .xcnt_o      (xcnt_o),
  .pmap_o      (pmap_o)
);

// File: tb/dma_chan_regs_tb.sv
`timescale 1ns/1ps
module dma_chan_regs_tb;
  localparam logic [15:0] PMAP_INIT = 16'h0045;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        wr = 1'b0, wide = 1'b1;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        upd = 1'b0, edone = 1'b0, eerr = 1'b0;
  logic [31:0] edesc = '0, eaddr = '0;
  logic [15:0] ex = '0, ey = '0;
  logic        run, start, stop, bad;
  logic [15:0] cfg, xc, xm, yc, ym, pm;
  logic [31:0] ndp, sa;

  dma_chan_regs #(.AW(6), .PMAP_RST(PMAP_INIT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_wide_i(wide),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .eng_upd_i(upd), .eng_desc_i(edesc), .eng_addr_i(eaddr),
    .eng_xcnt_i(ex), .eng_ycnt_i(ey), .eng_done_i(edone), .eng_err_i(eerr),
    .run_o(run), .start_o(start), .stop_o(stop), .bad_wr_o(bad),
    .cfg_o(cfg), .next_desc_o(ndp), .start_addr_o(sa), .xcnt_o(xc),
    .xmod_o(xm), .ycnt_o(yc), .ymod_o(ym), .pmap_o(pm)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0] mreg [16];
  bit m_run, m_done, m_err;
  bit x_start, x_stop, x_bad;

  function automatic logic [31:0] model_read(input int k, input bit w);
    logic [31:0] v;
    case (k)
      3, 13, 15: v = 32'h0;
      10: v = {28'h0, m_run, 1'b0, m_err, m_done};
      default: v = mreg[k];
    endcase
    return w ? v : (v & 32'h0000_FFFF);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mreg[k]) mreg[k] = 32'h0;
      mreg[11] = {16'h0, PMAP_INIT};
      m_run = 0; m_done = 0; m_err = 0;
      x_start = 0; x_stop = 0; x_bad = 0;
    end else begin
      int k;
      bit was_run, cfg_hit;
      k = int'(addr[5:2]);
      was_run = m_run;
      cfg_hit = wr && (k == 2);
      x_start = 0; x_stop = 0; x_bad = 0;
      if (edone) begin m_done = 1; m_run = 0; end
      if (eerr)  m_err = 1;
      if (wr) begin
        case (k)
          0, 1, 8, 9:
            if (!was_run) mreg[k] = wide ? wdata : {mreg[k][31:16], wdata[15:0]};
          2: begin
            mreg[2] = {16'h0, wdata[15:0]};
            m_run = wdata[0];
            x_start = wdata[0];
            x_stop  = !wdata[0];
          end
          4, 5, 6, 7, 12, 14:
            if (!was_run) mreg[k] = {16'h0, wdata[15:0]};
          10: begin
            if (wdata[0] && !edone) m_done = 0;
            if (wdata[1] && !eerr)  m_err  = 0;
          end
          11:
            if (!was_run) mreg[11] = {16'h0, (mreg[11][15:0] & 16'h0040) | (wdata[15:0] & 16'hFFBF)};
          default: x_bad = 1;
        endcase
      end
      if (upd) begin
        mreg[8] = edesc; mreg[9] = eaddr;
        mreg[12] = {16'h0, ex}; mreg[14] = {16'h0, ey};
      end
      if (cfg_hit) m_run = wdata[0];
      #3;
      check("R5/R7 run", {31'h0, run}, {31'h0, m_run});
      check("R5 start", {31'h0, start}, {31'h0, x_start});
      check("R5 stop", {31'h0, stop}, {31'h0, x_stop});
      check("R9 bad_wr", {31'h0, bad}, {31'h0, x_bad});
      check("R4 start_addr", sa, mreg[1]);
      check("R4 xcnt", {16'h0, xc}, mreg[4][31:0]);
      check("R8 pmap", {16'h0, pm}, mreg[11]);
      check("R5 cfg", {16'h0, cfg}, mreg[2]);
    end
  end

  task automatic step(input bit w, input bit wd, input logic [5:0] a, input logic [31:0] d,
                      input bit u, input logic [31:0] dd, input logic [31:0] aa,
                      input logic [15:0] xx, input logic [15:0] yy, input bit dn, input bit er);
    @(negedge clk);
    wr = w; wide = wd; addr = a; wdata = d;
    upd = u; edesc = dd; eaddr = aa; ex = xx; ey = yy; edone = dn; eerr = er;
    @(negedge clk);
    wr = 0; upd = 0; edone = 0; eerr = 0; wide = 1;
  endtask

  task automatic bw(input logic [5:0] a, input logic [31:0] d, input bit wd);
    step(1, wd, a, d, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic ev(input bit u, input logic [31:0] dd, input logic [31:0] aa,
                    input logic [15:0] xx, input logic [15:0] yy, input bit dn, input bit er);
    step(0, 1, 6'h0, 0, u, dd, aa, xx, yy, dn, er);
  endtask

  task automatic rd(input logic [5:0] a, input bit wd, input string req);
    @(negedge clk);
    wr = 0; addr = a; wide = wd;
    #1;
    check(req, rdata, model_read(int'(a[5:2]), wd));
  endtask

  task automatic rd_all(input string req);
    for (int k = 0; k < 16; k++) rd(6'(k * 4), 1, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd_all("R1 reset");
    check("R1 pmap reset", {16'h0, pm}, {16'h0, PMAP_INIT});

    // R3 full and half writes on 32-bit registers
    bw(6'h00, 32'h1234_5678, 1); bw(6'h00, 32'hFFFF_ABCD, 0);
    check("R3 ndp merge", ndp, 32'h1234_ABCD);
    bw(6'h04, 32'hCAFE_0004, 1); bw(6'h04, 32'h0000_0010, 0);
    bw(6'h20, 32'h0BAD_F00D, 1); bw(6'h24, 32'h7777_0000, 1); bw(6'h24, 32'h0000_1111, 0);
    // R3 16-bit registers keep only low half
    bw(6'h10, 32'hFFFF_0040, 1); bw(6'h14, 32'h0000_0004, 1);
    bw(6'h18, 32'h0000_0003, 0); bw(6'h1C, 32'hFFFF_FFF0, 1);
    bw(6'h30, 32'h0000_0022, 1); bw(6'h38, 32'h1234_0033, 1);
    rd_all("R3 after writes");
    // R2 half reads and address low bits ignored
    rd(6'h00, 0, "R2 half read ndp");
    rd(6'h26, 1, "R2 low bits ignored");
    rd(6'h24, 0, "R2 half read ca");

    // R8 routing word keeps channel-type bit
    bw(6'h2C, 32'h0000_00BA, 1);
    check("R8 pmap merge", {16'h0, pm}, 32'h0000_00FA);
    bw(6'h2C, 32'h0000_0000, 0);
    rd(6'h2C, 1, "R8 pmap keep bit6");

    // R9 unused slots
    bw(6'h0C, 32'hDEAD_BEEF, 1);
    bw(6'h34, 32'hDEAD_BEEF, 0);
    bw(6'h3C, 32'h1, 1);
    rd_all("R9 after unused writes");

    // R5 start, then R4 guarded writes
    bw(6'h08, 32'h0000_0081, 1);
    check("R5 running", {31'h0, run}, 32'h1);
    bw(6'h00, 32'h5555_5555, 1); bw(6'h04, 32'h6666_6666, 0);
    bw(6'h10, 32'h99, 1); bw(6'h2C, 32'hFFFF, 1); bw(6'h30, 32'h44, 1);
    bw(6'h20, 32'h1, 1); bw(6'h38, 32'h2, 1);
    rd_all("R4 guarded");
    bw(6'h08, 32'h0000_0083, 0);
    rd(6'h08, 1, "R5 cfg writable while running");

    // R10 engine updates
    ev(1, 32'hA000_0000, 32'hB000_0010, 16'h3F, 16'h2, 0, 0);
    rd_all("R10 engine update");
    // R7 error event, then done
    ev(0, 0, 0, 0, 0, 0, 1);
    rd(6'h28, 1, "R7 err set");
    ev(0, 0, 0, 0, 0, 1, 0);
    rd(6'h28, 1, "R7 done clears run");

    // R6 write-one-to-clear
    bw(6'h28, 32'h0, 1);
    rd(6'h28, 1, "R6 write zero keeps");
    bw(6'h28, 32'h2, 1);
    rd(6'h28, 1, "R6 clear err only");
    bw(6'h08, 32'h1, 1);
    bw(6'h28, 32'hFFFF, 1);
    rd(6'h28, 1, "R6 run not writable");
    // R7 set wins over same-cycle clear
    step(1, 1, 6'h28, 32'h3, 0, 0, 0, 0, 0, 1, 1);
    rd(6'h28, 1, "R7 set beats clear");

    // R10 engine priority over bus write when idle
    step(1, 1, 6'h30, 32'h1111, 1, 32'h1, 32'h2, 16'h77, 16'h88, 0, 0);
    rd(6'h30, 1, "R10 engine wins");
    rd(6'h20, 1, "R10 desc");

    // R5 start then stop
    bw(6'h08, 32'h1, 0);
    bw(6'h08, 32'h0, 0);
    check("R5 stopped", {31'h0, run}, 32'h0);
    bw(6'h10, 32'h5A, 1);
    rd(6'h10, 1, "R4 writable after stop");

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule